// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block drives a liquid-crystal panel that has four common lines and twenty segment lines. It uses four-way time multiplexing with two bias steps. Every output pin is produced as a 2-bit level code, and an external analog stage turns that code into a voltage. The codes are: `00` low, `01` middle, `10` high. Code `11` is never produced. The frame is split into four equal slots. In each slot one common line is selected and carries a full level, while the other three sit at the middle level. The polarity of the drive flips on every frame, so that each pixel sees no net DC.

The CPU side writes segment patterns into a pattern store that holds one 4-bit word per segment line. Bit k of word d is the pixel at the crossing of segment line d (0-based) and common line k. A write can go into the store directly. It can also pass through a one-word holding latch: in that case the store receives the latch's previous content and the latch takes the new data. Writes land in a shadow copy. The displayed copy takes over the shadow at the start of each slot.

The eight highest segment lines (indices 12 to 19) can be handed to a general-purpose port, one pin per control bit. Reset and the backup (oscillator stopped) input force every output to the low code. The frame then restarts from its first slot once both are released.

Top module: `lcd_mux_drv`

## Requirements
- R1: While `rstN` is low at a clock edge, all common and segment outputs carry the low code `00` after that edge. Reset clears the pattern store, the shown patterns and the holding latch. Reset is synchronous and active low.
- R2: While `backup` is high, every output is `00` at once. Stored patterns are kept. At the first clock edge with `backup` low, drive restarts in slot 0 with positive polarity and shows the stored patterns.
- R3: While driving, exactly one common line is not at the middle code `01`. That common is at `10` in positive frames and at `00` in negative frames.
- R4: The common lines are selected in the order 0, 1, 2, 3. Each slot lasts `SLOT_CLKS` clocks (default 250), which gives a frame of 1000 clocks. Slot 0 starts at the clock edge that ends reset or backup.
- R5: Polarity starts positive and inverts at every frame boundary.
- R6: A segment whose pixel bit for the selected common is 1 carries the level opposite to the selected common (`10` against `00`). A segment whose bit is 0 carries the same level as the selected common. Segment outputs never carry `01`.
- R7: Bit k of pattern word d controls segment line d while common k is selected.
- R8: A direct write (`wrEn`=1, `wrThru`=0) stores `wrData` into word `wrDigit`.
- R9: A latched write (`wrEn`=1, `wrThru`=1) stores the previous holding-latch value into word `wrDigit` and loads `wrData` into the latch.
- R10: A write becomes visible only at the start of the next slot. Within a slot, the outputs do not change unless the port controls change.
- R11: Bit i of `portLo` hands segment line 12+i to port use, and bit i of `portHi` hands segment line 16+i (1 = port, 0 = segment). A handed-over line outputs `00` and has its `segDrvEn` bit at 0. Every other line has `segDrvEn` at 1.
- R12: A write with `wrDigit` of 20 or more changes neither the store nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock (75 kHz nominal) |
| rstN | input | 1 | Synchronous active-low reset |
| backup | input | 1 | Backup mode, forces all outputs low |
| wrEn | input | 1 | Pattern write strobe |
| wrThru | input | 1 | 1 = write through holding latch, 0 = direct |
| wrDigit | input | 5 | Pattern word index (segment line) |
| wrData | input | 4 | Pixel bits, bit k for common k |
| portLo | input | 4 | Port hand-off for segment lines 12..15 |
| portHi | input | 4 | Port hand-off for segment lines 16..19 |
| comOut | output | 8 | Level codes of commons, common k at [2k+1:2k] |
| segOut | output | 40 | Level codes of segments, line d at [2d+1:2d] |
| segDrvEn | output | 20 | 1 where the driver owns the segment pin |

## Verification
Inputs are applied between clock edges. A write or a change of mode is captured at the next rising edge. A reference model in the bench updates the slot counter, polarity, shadow store and shown store at that same edge, in the same order as the requirements. Commons and segments are compared half a cycle after every edge, so a write is expected to stay invisible until the first edge where the slot count reaches a multiple of 250, and to appear right after it. Backup forcing acts without a clock, so it is due in the same cycle, while the restart is counted from the first edge after release.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

  localparam int LCD_COMS   = 4;
  localparam int LCD_SLOT_W = $clog2(LCD_COMS);
  localparam int LCD_LVL_W  = 2;

  typedef enum logic [LCD_LVL_W-1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lcdLevelT;

  // strobes from the frame timing to the datapath
  typedef struct packed {
    logic                  load;   // shadow -> shown at this edge
    logic                  blank;  // force all outputs low
    logic [LCD_SLOT_W-1:0] slot;   // selected common
    logic                  pol;    // 0 = positive frame
  } lcdCtlT;

endpackage

// File: rtl/lcd_mux_timing.sv
module lcd_mux_timing
  import lcd_mux_pkg::*;
#(
  parameter int SLOT_CLKS = 250
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   backup,
  output lcdCtlT ctl
);

  localparam int CNT_W = (SLOT_CLKS > 2) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CLKS - 1);
  localparam logic [LCD_SLOT_W-1:0] SLOT_LAST = LCD_SLOT_W'(LCD_COMS - 1);

  logic                  running;
  logic [CNT_W-1:0]      slotCnt;
  logic [LCD_SLOT_W-1:0] slotIdx;
  logic                  polarity;
  logic                  slotEnd;
  logic                  frameEnd;

  assign slotEnd  = running && (slotCnt == CNT_LAST);
  assign frameEnd = slotEnd && (slotIdx == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || backup) begin
      running  <= 1'b0;
      slotCnt  <= '0;
      slotIdx  <= '0;
      polarity <= 1'b0;
    end else if (!running) begin
      running  <= 1'b1;
      slotCnt  <= '0;
      slotIdx  <= '0;
      polarity <= 1'b0;
    end else if (slotEnd) begin
      slotCnt  <= '0;
      slotIdx  <= frameEnd ? '0 : slotIdx + 1'b1;
      polarity <= polarity ^ frameEnd;
    end else begin
      slotCnt  <= slotCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.load  = !backup && (!running || slotEnd);
    ctl.blank = backup || !running;
    ctl.slot  = slotIdx;
    ctl.pol   = polarity;
  end

endmodule

// File: rtl/lcd_mux_datapath.sv
module lcd_mux_datapath
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG    = 20,
  parameter int DIGIT_W    = 5,
  parameter int PORT_LINES = 8,
  parameter int PORT_FIRST = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  lcdCtlT                        ctl,
  input  logic                          wrEn,
  input  logic                          wrThru,
  input  logic [DIGIT_W-1:0]            wrDigit,
  input  logic [LCD_COMS-1:0]           wrData,
  input  logic [PORT_LINES-1:0]         portMask,
  output logic [LCD_LVL_W*LCD_COMS-1:0] comOut,
  output logic [LCD_LVL_W*NUM_SEG-1:0]  segOut,
  output logic [NUM_SEG-1:0]            segDrvEn
);

  logic [LCD_COMS-1:0] shadowPat [NUM_SEG];
  logic [LCD_COMS-1:0] shownPat  [NUM_SEG];
  logic [LCD_COMS-1:0] holdLatch;
  logic                digitOk;
  lcdLevelT            selLvl;
  lcdLevelT            antiLvl;

  assign digitOk = ({1'b0, wrDigit} < (DIGIT_W+1)'(NUM_SEG));

  // CPU-side store and holding latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEG; i++) shadowPat[i] <= '0;
      holdLatch <= '0;
    end else if (wrEn && digitOk) begin
      if (wrThru) begin
        shadowPat[wrDigit] <= holdLatch;
        holdLatch          <= wrData;
      end else begin
        shadowPat[wrDigit] <= wrData;
      end
    end
  end

  // shown copy refreshes only at slot starts
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEG; i++) shownPat[i] <= '0;
    end else if (ctl.load) begin
      for (int i = 0; i < NUM_SEG; i++) shownPat[i] <= shadowPat[i];
    end
  end

  assign selLvl  = ctl.pol ? LVL_LOW  : LVL_HIGH;
  assign antiLvl = ctl.pol ? LVL_HIGH : LVL_LOW;

  for (genvar c = 0; c < LCD_COMS; c++) begin : g_com
    lcdLevelT comLvl;
    always_comb begin
      if (ctl.blank)                           comLvl = LVL_LOW;
      else if (ctl.slot == LCD_SLOT_W'(c))     comLvl = selLvl;
      else                                     comLvl = LVL_MID;
    end
    assign comOut[LCD_LVL_W*c +: LCD_LVL_W] = comLvl;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic     isPort;
    logic     pixelOn;
    lcdLevelT segLvl;
    if (s >= PORT_FIRST) begin : g_shared
      assign isPort = portMask[s - PORT_FIRST];
    end else begin : g_fixed
      assign isPort = 1'b0;
    end
    assign pixelOn = shownPat[s][ctl.slot];
    always_comb begin
      if (ctl.blank || isPort) segLvl = LVL_LOW;
      else if (pixelOn)        segLvl = antiLvl;
      else                     segLvl = selLvl;
    end
    assign segOut[LCD_LVL_W*s +: LCD_LVL_W] = segLvl;
    assign segDrvEn[s] = !isPort;
  end

endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG   = 20,
  parameter int SLOT_CLKS = 250,
  localparam int DIGIT_W  = $clog2(NUM_SEG),
  localparam int NIB_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          backup,
  input  logic                          wrEn,
  input  logic                          wrThru,
  input  logic [DIGIT_W-1:0]            wrDigit,
  input  logic [LCD_COMS-1:0]           wrData,
  input  logic [NIB_W-1:0]              portLo,
  input  logic [NIB_W-1:0]              portHi,
  output logic [LCD_LVL_W*LCD_COMS-1:0] comOut,
  output logic [LCD_LVL_W*NUM_SEG-1:0]  segOut,
  output logic [NUM_SEG-1:0]            segDrvEn
);

  localparam int PORT_LINES = 2 * NIB_W;
  localparam int PORT_FIRST = NUM_SEG - PORT_LINES;

  lcdCtlT ctl;

  lcd_mux_timing #(.SLOT_CLKS(SLOT_CLKS)) u_timing (
    .clk    (clk),
    .rstN   (rstN),
    .backup (backup),
    .ctl    (ctl)
  );

  lcd_mux_datapath #(
    .NUM_SEG    (NUM_SEG),
    .DIGIT_W    (DIGIT_W),
    .PORT_LINES (PORT_LINES),
    .PORT_FIRST (PORT_FIRST)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrEn     (wrEn),
    .wrThru   (wrThru),
    .wrDigit  (wrDigit),
    .wrData   (wrData),
    .portMask ({portHi, portLo}),
    .comOut   (comOut),
    .segOut   (segOut),
    .segDrvEn (segDrvEn)
  );

endmodule

// File: rtl/lcd_mux_drv_chk.sv
module lcd_mux_drv_chk
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG = 20
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          backup,
  input logic [3:0]                    portLo,
  input logic [3:0]                    portHi,
  input logic [LCD_LVL_W*LCD_COMS-1:0] comOut,
  input logic [LCD_LVL_W*NUM_SEG-1:0]  segOut,
  input logic                          ctlLoad
);

  localparam int PORT_FIRST = NUM_SEG - 8;

  logic [LCD_COMS-1:0] comNonMid;
  logic [NUM_SEG-1:0]  segOddCode;
  logic [7:0]          portBad;
  logic [7:0]          portMask;

  assign portMask = {portHi, portLo};

  for (genvar c = 0; c < LCD_COMS; c++) begin : g_c
    assign comNonMid[c] = (comOut[2*c +: 2] != 2'b01);
  end
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_s
    assign segOddCode[s] = segOut[2*s];
  end
  for (genvar i = 0; i < 8; i++) begin : g_p
    assign portBad[i] = portMask[i] && (segOut[2*(PORT_FIRST+i) +: 2] != 2'b00);
  end

  p_reset_low_r1: assert property (@(posedge clk)
    !rstN |=> (comOut == '0 && segOut == '0));

  p_backup_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    backup |-> (comOut == '0 && segOut == '0));

  p_one_common_r3: assert property (@(posedge clk) disable iff (!rstN)
    (comOut != '0) |-> ($countones(comNonMid) == 1));

  p_two_level_seg_r6: assert property (@(posedge clk) disable iff (!rstN)
    segOddCode == '0);

  p_hold_com_r10: assert property (@(posedge clk) disable iff (!rstN || backup)
    (!$past(ctlLoad) && $past(comOut) != '0) |-> $stable(comOut));

  p_hold_seg_r10: assert property (@(posedge clk) disable iff (!rstN || backup)
    (!$past(ctlLoad) && $past(comOut) != '0 && $stable(portLo) && $stable(portHi))
      |-> $stable(segOut));

  p_port_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    portBad == '0);

endmodule

bind lcd_mux_drv lcd_mux_drv_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .backup  (backup),
  .portLo  (portLo),
  .portHi  (portHi),
  .comOut  (comOut),
  .segOut  (segOut),
  .ctlLoad (ctl.load)
);

// File: tb/lcd_mux_drv_test.sv
module lcd_mux_drv_test;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SEG    = 20;
  localparam int SLOT_CLKS  = 250;
  localparam int COMS       = 4;

  logic        clk = 1'b0;
  logic        rstN, backup, wrEn, wrThru;
  logic [4:0]  wrDigit;
  logic [3:0]  wrData, portLo, portHi;
  logic [7:0]  comOut;
  logic [39:0] segOut;
  logic [19:0] segDrvEn;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [3:0] mShadow [NUM_SEG];
  logic [3:0] mShown  [NUM_SEG];
  logic [3:0] mLatch;
  bit         mRun;
  int         mT;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_mux_drv #(.NUM_SEG(NUM_SEG), .SLOT_CLKS(SLOT_CLKS)) uut (
    .clk(clk), .rstN(rstN), .backup(backup), .wrEn(wrEn), .wrThru(wrThru),
    .wrDigit(wrDigit), .wrData(wrData), .portLo(portLo), .portHi(portHi),
    .comOut(comOut), .segOut(segOut), .segDrvEn(segDrvEn)
  );

  task automatic modelEdge();
    logic [3:0] old [NUM_SEG];
    old = mShadow;
    if (!rstN) begin
      for (int i = 0; i < NUM_SEG; i++) begin mShadow[i] = 4'h0; mShown[i] = 4'h0; end
      mLatch = 4'h0; mRun = 0; mT = 0;
    end else begin
      if (backup) begin mRun = 0; mT = 0; end
      else if (!mRun) begin mRun = 1; mT = 0; mShown = old; end
      else begin mT++; if (mT % SLOT_CLKS == 0) mShown = old; end
      if (wrEn && wrDigit < NUM_SEG) begin
        if (wrThru) begin mShadow[wrDigit] = mLatch; mLatch = wrData; end
        else mShadow[wrDigit] = wrData;
      end
    end
  endtask

  function automatic bit isBlank();
    return !mRun || backup;
  endfunction

  function automatic logic [7:0] expCom();
    logic [7:0] v = '0;
    int slot = (mT / SLOT_CLKS) % COMS;
    int pol  = (mT / (COMS*SLOT_CLKS)) % 2;
    if (isBlank()) return '0;
    for (int c = 0; c < COMS; c++)
      v[2*c +: 2] = (c == slot) ? (pol ? 2'b00 : 2'b10) : 2'b01;
    return v;
  endfunction

  function automatic logic [19:0] expEn();
    return ~{portHi, portLo, 12'h000};
  endfunction

  function automatic logic [39:0] expSeg();
    logic [39:0] v = '0;
    logic [19:0] en = expEn();
    int slot = (mT / SLOT_CLKS) % COMS;
    int pol  = (mT / (COMS*SLOT_CLKS)) % 2;
    logic [1:0] sel  = pol ? 2'b00 : 2'b10;
    logic [1:0] anti = pol ? 2'b10 : 2'b00;
    if (isBlank()) return '0;
    for (int s = 0; s < NUM_SEG; s++)
      v[2*s +: 2] = !en[s] ? 2'b00 : (mShown[s][slot] ? anti : sel);
    return v;
  endfunction

  task automatic checkAll(input string tag);
    logic [7:0]  ec = expCom();
    logic [39:0] es = expSeg();
    logic [19:0] ee = expEn();
    string bt = isBlank() ? "R1 R2 forced low" : "";
    checks++;
    if (comOut !== ec) begin
      errors++;
      $display("FAIL %s commons at t=%0d: actual %h expected %h",
               isBlank() ? bt : "R3 R4 R5 slot/polarity", mT, comOut, ec);
    end
    checks++;
    if (segOut !== es) begin
      errors++;
      $display("FAIL %s segments at t=%0d: actual %h expected %h",
               isBlank() ? bt : tag, mT, segOut, es);
    end
    checks++;
    if (segDrvEn !== ee) begin
      errors++;
      $display("FAIL R11 drive enables: actual %h expected %h", segDrvEn, ee);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkAll(tag);
  endtask

  // mode 0 direct, 1 mixed with latched, 2 any index
  task automatic driveRandom(input int mode);
    wrEn    = ($urandom % 4) == 0;
    wrThru  = (mode == 1) ? 1'($urandom % 2) : 1'b0;
    wrDigit = (mode == 2) ? 5'($urandom % 32) : 5'($urandom % NUM_SEG);
    wrData  = 4'($urandom);
  endtask

  task automatic idleWrite();
    wrEn = 0; wrThru = 0; wrDigit = '0; wrData = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog R4 run: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 0; backup = 0; portLo = 0; portHi = 0;
    idleWrite();
    @(negedge clk);
    repeat (5) step("R1");

    // R6 R7 R8: direct writes with random patterns, port masks changing
    rstN = 1;
    for (int n = 0; n < 2400; n++) begin
      if (n % 500 == 499) begin portLo = 4'($urandom); portHi = 4'($urandom); end
      driveRandom(0);
      step("R6 R7 R8 R11");
    end

    // R9: latched writes mixed in
    for (int n = 0; n < 2000; n++) begin
      driveRandom(1);
      step("R9 latched write");
    end

    // R12: indices beyond the last segment line
    portLo = 0; portHi = 0;
    for (int n = 0; n < 600; n++) begin
      driveRandom(2);
      if (n % 3 == 0) begin wrEn = 1; wrThru = 1'($urandom % 2); wrDigit = 5'(20 + $urandom % 12); end
      step("R12 out of range");
    end

    // R10: write in the middle of a slot, must stay hidden until the boundary
    idleWrite();
    while (mT % SLOT_CLKS != 100) step("R10");
    wrEn = 1; wrThru = 0; wrDigit = 5'd3; wrData = ~mShadow[3];
    step("R10 mid-slot write");
    idleWrite();
    for (int n = 0; n < 400; n++) step("R10 hold until slot start");

    // R2: backup with writes, then release
    backup = 1;
    for (int n = 0; n < 300; n++) begin driveRandom(0); step("R2 backup"); end
    backup = 0;
    for (int n = 0; n < 1500; n++) begin driveRandom(0); step("R2 restart"); end

    // R1 R9: reset in the middle of a run clears store and latch
    idleWrite();
    rstN = 0;
    repeat (3) step("R1");
    rstN = 1;
    wrEn = 1; wrThru = 1; wrDigit = 5'd7; wrData = 4'hF;
    step("R1 R9 latch cleared by reset");
    idleWrite();
    for (int n = 0; n < 1100; n++) begin driveRandom(1); step("R1 R9 after reset"); end

    summary();
    $finish;
  end

endmodule